// File: doc/BRIEF.md
# Indirect Address Pointer Unit

This block keeps a small set of 12-bit pointers into data memory and turns indirect-access requests into data-memory addresses. Software-visible writes set a pointer in one of two ways. A full write sets all 12 bits at once. A byte write sets either the upper part or the lower 8 bits and leaves the other part as it was.

Two access ports can each name a pointer and an access mode in the same cycle. This lets a memory-to-memory move walk a source and a destination pointer together. Each port returns its effective address combinationally in the request cycle. The selected pointer then takes its new value at the next clock edge. The indexed mode adds the current W register value, supplied on an input, to the pointer.

Two ports naming the same pointer in one cycle is not supported; the bench never does it. The data memory itself is not part of the block.

Top module: `ptr_unit`

## Requirements
- R1: After reset every pointer reads 0, so a plain access to any pointer returns address 0x000.
- R2: A full write (`ld_en_i`) stores `ld_val_i` in pointer `ld_sel_i`. Accesses from the following cycle on see the new value.
- R3: A byte write with `bw_hi_i`=1 puts `bw_data_i[3:0]` into pointer bits 11:8, and `bw_data_i[7:4]` has no effect. With `bw_hi_i`=0 it puts `bw_data_i` into bits 7:0. In both cases the other bits are kept.
- R4: Mode 0 (plain) returns the pointer value and leaves the pointer unchanged.
- R5: Mode 1 (post-increment) returns the current value, and the pointer becomes value+1 at the next edge.
- R6: Mode 2 (post-decrement) returns the current value, and the pointer becomes value-1 at the next edge.
- R7: Mode 3 (pre-increment) returns value+1, and the pointer becomes value+1 at the next edge.
- R8: Mode 4 (W-indexed) returns pointer + `w_i`, with `w_i` taken as unsigned. The pointer is unchanged.
- R9: All pointer and address arithmetic wraps modulo 4096: 0xFFF+1 gives 0x000, and 0x000-1 gives 0xFFF.
- R10: Two ports naming different pointers in the same cycle each return their own address, and both pointers update at the same edge.
- R11: A full write or byte write to a pointer beats an access-mode update of that pointer in the same cycle. A full write beats a byte write to the same pointer.
- R12: Mode codes 5 to 7 behave as plain. A port whose `acc_en_i` bit is low returns address 0 and changes no pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| w_i | input | 8 | W register value for indexed mode |
| ld_en_i | input | 1 | Full pointer write enable |
| ld_sel_i | input | 2 | Pointer chosen for the full write |
| ld_val_i | input | 12 | Full write value |
| bw_en_i | input | 1 | Byte write enable |
| bw_sel_i | input | 2 | Pointer chosen for the byte write |
| bw_hi_i | input | 1 | 1 selects the upper part, 0 the lower byte |
| bw_data_i | input | 8 | Byte write data |
| acc_en_i | input | 2 | Access request, one bit per port |
| acc_sel_i | input | 2x2 | Pointer selected by each port |
| acc_mode_i | input | 2x3 | Access mode of each port |
| acc_addr_o | output | 2x12 | Effective address of each port |

## Verification
Each effective address is due in the same cycle as its request, because it is combinational from the pointer registers and the port inputs. The bench drives inputs at the falling edge, lets them settle briefly, and compares both ports' addresses against a behavioural model before the next rising edge. Pointer updates are due one edge later. The model applies them only after that cycle's comparison, so every write or mode side effect shows up in the addresses of the following cycle.

// File: rtl/ptr_pkg.sv
package ptr_pkg;
  typedef enum logic [2:0] {
    MODE_PLAIN    = 3'd0,
    MODE_POST_INC = 3'd1,
    MODE_POST_DEC = 3'd2,
    MODE_PRE_INC  = 3'd3,
    MODE_W_IDX    = 3'd4
  } ptr_mode_e;
endpackage

// File: rtl/ptr_calc.sv
module ptr_calc
  import ptr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int W_W    = 8
) (
  input  logic [ADDR_W-1:0] ptr_i,
  input  logic [2:0]        mode_i,
  input  logic [W_W-1:0]    w_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] next_o,
  output logic              upd_o
);
  logic [ADDR_W-1:0] inc, dec, idx;

  assign inc = ptr_i + ADDR_W'(1);
  assign dec = ptr_i - ADDR_W'(1);
  assign idx = ptr_i + ADDR_W'(w_i);  // unsigned W, wraps

  always_comb begin
    addr_o = ptr_i;
    next_o = ptr_i;
    upd_o  = 1'b0;
    case (mode_i)
      MODE_POST_INC: begin next_o = inc; upd_o = 1'b1; end
      MODE_POST_DEC: begin next_o = dec; upd_o = 1'b1; end
      MODE_PRE_INC:  begin addr_o = inc; next_o = inc; upd_o = 1'b1; end
      MODE_W_IDX:    addr_o = idx;
      default: ;
    endcase
  end
endmodule

// File: rtl/ptr_reg.sv
module ptr_reg #(
  parameter int ADDR_W    = 12,
  parameter int NUM_PORTS = 2
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              ld_hit_i,
  input  logic [ADDR_W-1:0]                 ld_val_i,
  input  logic                              bw_hit_i,
  input  logic                              bw_hi_i,
  input  logic [7:0]                        bw_data_i,
  input  logic [NUM_PORTS-1:0]              upd_hit_i,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0]  upd_val_i,
  output logic [ADDR_W-1:0]                 ptr_o
);
  localparam int LO_W = 8;
  localparam int HI_W = ADDR_W - LO_W;

  logic [ADDR_W-1:0] q, nxt;

  always_comb begin
    nxt = q;
    // lower port index wins if two ports collide
    for (int i = NUM_PORTS - 1; i >= 0; i--) begin
      if (upd_hit_i[i]) nxt = upd_val_i[i];
    end
    if (bw_hit_i) begin
      if (bw_hi_i) nxt = {bw_data_i[HI_W-1:0], q[LO_W-1:0]};
      else         nxt = {q[ADDR_W-1:LO_W], bw_data_i};
    end
    if (ld_hit_i) nxt = ld_val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= nxt;
  end

  assign ptr_o = q;
endmodule

// File: rtl/ptr_unit.sv
module ptr_unit #(
  parameter int NUM_PTRS  = 3,
  parameter int NUM_PORTS = 2,
  parameter int ADDR_W    = 12,
  parameter int W_W       = 8,
  localparam int SEL_W    = (NUM_PTRS > 1) ? $clog2(NUM_PTRS) : 1
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [W_W-1:0]                    w_i,
  input  logic                              ld_en_i,
  input  logic [SEL_W-1:0]                  ld_sel_i,
  input  logic [ADDR_W-1:0]                 ld_val_i,
  input  logic                              bw_en_i,
  input  logic [SEL_W-1:0]                  bw_sel_i,
  input  logic                              bw_hi_i,
  input  logic [7:0]                        bw_data_i,
  input  logic [NUM_PORTS-1:0]              acc_en_i,
  input  logic [NUM_PORTS-1:0][SEL_W-1:0]   acc_sel_i,
  input  logic [NUM_PORTS-1:0][2:0]         acc_mode_i,
  output logic [NUM_PORTS-1:0][ADDR_W-1:0]  acc_addr_o
);
  localparam logic [SEL_W:0] SEL_LIM = (SEL_W + 1)'(NUM_PTRS);

  logic [NUM_PTRS-1:0][ADDR_W-1:0]  ptr_q;
  logic [NUM_PORTS-1:0][ADDR_W-1:0] cur_ptr, calc_addr, calc_next;
  logic [NUM_PORTS-1:0]             calc_upd, port_ok;

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    assign port_ok[g] = acc_en_i[g] && ({1'b0, acc_sel_i[g]} < SEL_LIM);
    assign cur_ptr[g] = port_ok[g] ? ptr_q[acc_sel_i[g]] : '0;

    ptr_calc #(.ADDR_W(ADDR_W), .W_W(W_W)) calc_i (
      .ptr_i  (cur_ptr[g]),
      .mode_i (acc_mode_i[g]),
      .w_i    (w_i),
      .addr_o (calc_addr[g]),
      .next_o (calc_next[g]),
      .upd_o  (calc_upd[g])
    );

    assign acc_addr_o[g] = port_ok[g] ? calc_addr[g] : '0;
  end

  for (genvar j = 0; j < NUM_PTRS; j++) begin : g_ptr
    logic [NUM_PORTS-1:0] hit;
    for (genvar k = 0; k < NUM_PORTS; k++) begin : g_hit
      assign hit[k] = port_ok[k] && calc_upd[k] && (acc_sel_i[k] == SEL_W'(j));
    end

    ptr_reg #(.ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS)) reg_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ld_hit_i  (ld_en_i && (ld_sel_i == SEL_W'(j))),
      .ld_val_i  (ld_val_i),
      .bw_hit_i  (bw_en_i && (bw_sel_i == SEL_W'(j))),
      .bw_hi_i   (bw_hi_i),
      .bw_data_i (bw_data_i),
      .upd_hit_i (hit),
      .upd_val_i (calc_next),
      .ptr_o     (ptr_q[j])
    );
  end
endmodule

// File: rtl/ptr_unit_chk.sv
module ptr_unit_chk #(
  parameter int NUM_PTRS  = 3,
  parameter int NUM_PORTS = 2,
  parameter int ADDR_W    = 12,
  parameter int SEL_W     = 2
) (
  input logic                              clk_i,
  input logic                              rst_ni,
  input logic                              ld_en_i,
  input logic [SEL_W-1:0]                  ld_sel_i,
  input logic [ADDR_W-1:0]                 ld_val_i,
  input logic                              bw_en_i,
  input logic [SEL_W-1:0]                  bw_sel_i,
  input logic [NUM_PORTS-1:0]              acc_en_i,
  input logic [NUM_PORTS-1:0][SEL_W-1:0]   acc_sel_i,
  input logic [NUM_PORTS-1:0][2:0]         acc_mode_i,
  input logic [NUM_PORTS-1:0][ADDR_W-1:0]  acc_addr_o,
  input logic [NUM_PTRS-1:0][ADDR_W-1:0]   ptr_q
);
  localparam logic [SEL_W:0] SEL_LIM = (SEL_W + 1)'(NUM_PTRS);

  logic sel_ok0, ld_ok, solo0;
  assign sel_ok0 = acc_en_i[0] && ({1'b0, acc_sel_i[0]} < SEL_LIM);
  assign ld_ok   = ld_en_i && ({1'b0, ld_sel_i} < SEL_LIM);
  // port 0 is the only writer of its pointer this cycle
  assign solo0 = sel_ok0
    && !(ld_en_i && ld_sel_i == acc_sel_i[0])
    && !(bw_en_i && bw_sel_i == acc_sel_i[0])
    && !(acc_en_i[1] && acc_sel_i[1] == acc_sel_i[0]);

  AST_LOAD_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_ok |=> ptr_q[$past(ld_sel_i)] == $past(ld_val_i)); // R11

  AST_POST_INC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    solo0 && acc_mode_i[0] == 3'd1
    |=> ptr_q[$past(acc_sel_i[0])] == ADDR_W'($past(acc_addr_o[0]) + ADDR_W'(1))); // R5

  AST_POST_DEC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    solo0 && acc_mode_i[0] == 3'd2
    |=> ptr_q[$past(acc_sel_i[0])] == ADDR_W'($past(acc_addr_o[0]) - ADDR_W'(1))); // R6

  AST_PRE_INC_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    solo0 && acc_mode_i[0] == 3'd3
    |=> ptr_q[$past(acc_sel_i[0])] == $past(acc_addr_o[0])); // R7

  AST_W_IDX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    solo0 && acc_mode_i[0] == 3'd4
    |=> ptr_q[$past(acc_sel_i[0])] == $past(ptr_q[acc_sel_i[0]])); // R8

  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_en_i[0] |-> acc_addr_o[0] == '0); // R12
endmodule

bind ptr_unit ptr_unit_chk #(
  .NUM_PTRS(NUM_PTRS), .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .SEL_W(SEL_W)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ld_en_i    (ld_en_i),
  .ld_sel_i   (ld_sel_i),
  .ld_val_i   (ld_val_i),
  .bw_en_i    (bw_en_i),
  .bw_sel_i   (bw_sel_i),
  .acc_en_i   (acc_en_i),
  .acc_sel_i  (acc_sel_i),
  .acc_mode_i (acc_mode_i),
  .acc_addr_o (acc_addr_o),
  .ptr_q      (ptr_q)
);

// File: tb/ptr_unit_tb_top.sv
`timescale 1ns/1ps
module ptr_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0]       w;
  logic             ld_en;
  logic [1:0]       ld_sel;
  logic [11:0]      ld_val;
  logic             bw_en;
  logic [1:0]       bw_sel;
  logic             bw_hi;
  logic [7:0]       bw_data;
  logic [1:0]       acc_en;
  logic [1:0][1:0]  acc_sel;
  logic [1:0][2:0]  acc_mode;
  logic [1:0][11:0] acc_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int model [3];

  always #10 clk = ~clk;

  ptr_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .w_i(w),
    .ld_en_i(ld_en), .ld_sel_i(ld_sel), .ld_val_i(ld_val),
    .bw_en_i(bw_en), .bw_sel_i(bw_sel), .bw_hi_i(bw_hi), .bw_data_i(bw_data),
    .acc_en_i(acc_en), .acc_sel_i(acc_sel), .acc_mode_i(acc_mode),
    .acc_addr_o(acc_addr)
  );

  function automatic int exp_addr(int p);
    int v;
    if (!acc_en[p] || acc_sel[p] > 2) return 0;
    v = model[acc_sel[p]];
    case (acc_mode[p])
      3'd3:    return (v + 1) & 12'hFFF;
      3'd4:    return (v + int'(w)) & 12'hFFF;
      default: return v;
    endcase
  endfunction

  task automatic idle();
    w = '0; ld_en = 0; ld_sel = '0; ld_val = '0;
    bw_en = 0; bw_sel = '0; bw_hi = 0; bw_data = '0;
    acc_en = '0; acc_sel = '0; acc_mode = '0;
  endtask

  task automatic acc(int p, int sel, int mode);
    acc_en[p] = 1'b1; acc_sel[p] = 2'(sel); acc_mode[p] = 3'(mode);
  endtask

  // Check both ports mid-cycle, then advance the model and the clock.
  task automatic step(string tag);
    int nm [3];
    #2;
    for (int p = 0; p < 2; p++) begin
      int e;
      e = exp_addr(p);
      checks++;
      if (int'(acc_addr[p]) != e) begin
        errors++;
        $display("FAIL %s port %0d addr actual %03h expected %03h", tag, p, acc_addr[p], e);
      end
    end
    nm = model;
    for (int p = 1; p >= 0; p--) begin
      if (acc_en[p] && acc_sel[p] <= 2) begin
        case (acc_mode[p])
          3'd1, 3'd3: nm[acc_sel[p]] = (model[acc_sel[p]] + 1) & 12'hFFF;
          3'd2:       nm[acc_sel[p]] = (model[acc_sel[p]] + 4095) & 12'hFFF;
          default: ;
        endcase
      end
    end
    if (bw_en && bw_sel <= 2) begin
      if (bw_hi) nm[bw_sel] = ((int'(bw_data) & 4'hF) << 8) | (model[bw_sel] & 8'hFF);
      else       nm[bw_sel] = (model[bw_sel] & 12'hF00) | int'(bw_data);
    end
    if (ld_en && ld_sel <= 2) nm[ld_sel] = int'(ld_val);
    @(posedge clk);
    model = nm;
    @(negedge clk);
    idle();
  endtask

  task automatic load(int sel, int val, string tag);
    ld_en = 1; ld_sel = 2'(sel); ld_val = 12'(val);
    step(tag);
  endtask

  initial begin
    idle();
    model = '{0, 0, 0};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: all pointers zero after reset
    acc(0, 0, 0); acc(1, 1, 0); step("R1");
    acc(0, 2, 0); step("R1");

    // R2: full write then use
    load(1, 12'h120, "R2");
    load(2, 12'h150, "R2");
    acc(0, 1, 0); acc(1, 2, 0); step("R2");

    // R10 / R5: dual post-increment on different pointers
    acc(0, 1, 1); acc(1, 2, 1); step("R10");
    acc(0, 1, 0); acc(1, 2, 0); step("R5");

    // R3: byte writes, upper nibble of hi data ignored
    bw_en = 1; bw_sel = 0; bw_hi = 1; bw_data = 8'hFA; step("R3");
    acc(0, 0, 0); step("R3");
    bw_en = 1; bw_sel = 0; bw_hi = 0; bw_data = 8'h34; step("R3");
    acc(0, 0, 0); step("R3");

    // R4 plain keeps, R6 post-dec, R7 pre-inc
    acc(0, 0, 0); step("R4");
    acc(1, 0, 0); step("R4");
    acc(0, 0, 2); step("R6");
    acc(0, 0, 0); step("R6");
    acc(1, 0, 3); step("R7");
    acc(0, 0, 0); step("R7");

    // R8: W-indexed, pointer untouched
    w = 8'hFF; acc(0, 0, 4); step("R8");
    acc(0, 0, 0); step("R8");

    // R9: wrap cases
    load(2, 12'hFFF, "R9");
    acc(1, 2, 1); step("R9");
    acc(1, 2, 0); step("R9");
    acc(1, 2, 2); step("R9");
    acc(1, 2, 3); step("R9");
    load(2, 12'hFFF, "R9");
    w = 8'h02; acc(0, 2, 4); step("R9");

    // R11: write beats auto-update, full beats byte
    ld_en = 1; ld_sel = 1; ld_val = 12'h3C0; acc(0, 1, 1); step("R11");
    acc(0, 1, 0); step("R11");
    bw_en = 1; bw_sel = 1; bw_hi = 0; bw_data = 8'h55; acc(1, 1, 2); step("R11");
    acc(0, 1, 0); step("R11");
    ld_en = 1; ld_sel = 1; ld_val = 12'h777;
    bw_en = 1; bw_sel = 1; bw_hi = 1; bw_data = 8'h02; step("R11");
    acc(0, 1, 0); step("R11");

    // R12: modes 5..7 plain, disabled port
    for (int m = 5; m < 8; m++) begin
      acc(0, 1, m); step("R12");
    end
    acc(0, 1, 0); step("R12");
    acc_sel[1] = 2'd1; acc_mode[1] = 3'd1; step("R12");
    acc(0, 1, 0); step("R12");

    // Mixed traffic, ports on distinct pointers
    for (int i = 0; i < 400; i++) begin
      int s0;
      s0 = $urandom_range(2);
      w = 8'($urandom);
      if ($urandom_range(3) != 0) acc(0, s0, $urandom_range(7));
      if ($urandom_range(3) != 0) acc(1, (s0 + 1 + $urandom_range(1)) % 3, $urandom_range(7));
      if ($urandom_range(9) == 0) begin
        ld_en = 1; ld_sel = 2'($urandom_range(2)); ld_val = 12'($urandom);
      end
      if ($urandom_range(9) == 0) begin
        bw_en = 1; bw_sel = 2'($urandom_range(2)); bw_hi = 1'($urandom); bw_data = 8'($urandom);
      end
      step("R10");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(100000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1 actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule